// File: doc/BRIEF.md
# E1 Receive Line Decoder with Code-Violation Flag

This block sits behind the slicer and clock recovery of an E1 receiver. It takes the recovered positive and negative rails, one mark per bit period, and hands terminal equipment three things: a data output, a shared output that carries either negative-rail data or a code-violation flag, and a receive clock. In single-rail operation it decodes HDB3 or AMI line code. In dual-rail operation it passes both rails through. When loss of signal is reported it either freezes its outputs or, with muting enabled, drives fixed idle levels and lowers a loss-of-clock flag.

The block runs on `clk` at twice the bit rate. A two-state phase machine (`PH_FIRST`, `PH_SECOND`) advances every cycle while `los_n_i` is high. The cycle leaving `PH_SECOND` is the bit edge: the rails are sampled there and the data outputs update there. The transition `PH_FIRST`->`PH_SECOND` is the mid-bit edge and the transition `PH_SECOND`->`PH_FIRST` is the bit edge. The HDB3/AMI decoder is a six-state zero-run machine. `DS_VOID` means no mark has been seen since reset. `DS_MARK` means the last bit was a mark. `DS_ZERO1`, `DS_ZERO2` and `DS_ZERO3` count one, two and three zeros after a mark, and `DS_ZLONG` means four or more zeros. Any mark moves the machine to `DS_MARK`. A zero moves it one step along `DS_MARK`->`DS_ZERO1`->`DS_ZERO2`->`DS_ZERO3`->`DS_ZLONG`, where it stays. In `DS_VOID` a zero keeps it in `DS_VOID`. A four-stage delay line holds decoded bits, so that a substitution can be undone after it is recognised.

Top module: `e1_rx_decoder`

## Requirements
- R1: While `rst_n` is low, `data_o`=0, `neg_lcv_o`=0, `rclk_o`=0 and `clklos_n_o`=1, and the decoder delay line holds zeros.
- R2: With `mode_i`=2'b00 or 2'b11 (dual rail) and `pol_inv_i`=0, the rails sampled at a bit edge appear on `data_o` (positive rail) and `neg_lcv_o` (negative rail) right after that same edge, unchanged, with both rails high passed as is.
- R3: `rclk_o` changes every cycle while `los_n_i` is high. Outputs update only on the edge where `rclk_o` falls, or, in dual rail with `pol_inv_i`=1, on the edge where it rises; in that case `data_o` and `neg_lcv_o` are inverted (active low). In single rail, `pol_inv_i` has no effect.
- R4: With `mode_i`=2'b01 (HDB3), a valid HDB3 stream is decoded to its source bits, and the bit sampled at bit edge k appears on `data_o` after bit edge k+4. In this mode `neg_lcv_o` is the violation flag and stays 0 for a valid stream.
- R5: In HDB3, a mark of the same polarity as the previous mark is a violation pulse. It is removed and the three positions before it are cleared, but only when it ends 000V (exactly three zeros since the last mark) or B00V (exactly two zeros since the last mark, which is the B).
- R6: In HDB3, `neg_lcv_o` is high for the one bit period after a violation pulse is sampled if that pulse has the same polarity as the previous violation pulse or does not end a 000V/B00V pattern. A pulse that fails the pattern test is decoded as a 1 and is not removed.
- R7: With `mode_i`=2'b10 (AMI), every mark decodes to 1 with the same four-bit latency, and a mark with the same polarity as the previous mark raises `neg_lcv_o` for one bit period.
- R8: With `mute_en_i`=1 and `los_n_i`=0, one cycle later `clklos_n_o`=0. In dual rail with `pol_inv_i`=0 the outputs are `rclk_o`=1 and `data_o`=`neg_lcv_o`=0. In dual rail with `pol_inv_i`=1 they are `rclk_o`=0 and `data_o`=`neg_lcv_o`=1. In single rail they are `rclk_o`=1 and `data_o`=`neg_lcv_o`=0.
- R9: With `los_n_i`=0 and `mute_en_i`=0, `rclk_o`, `data_o` and `neg_lcv_o` hold their values, `clklos_n_o` stays 1, and the rails are ignored: after recovery the decoded stream continues as if the pause had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_pos_i | input | 1 | Recovered positive-rail mark |
| rx_neg_i | input | 1 | Recovered negative-rail mark |
| los_n_i | input | 1 | Loss of signal, active low |
| mute_en_i | input | 1 | Enables forced idle outputs during loss of signal |
| pol_inv_i | input | 1 | Output polarity/edge select (dual rail only) |
| mode_i | input | 2 | 00/11 dual rail, 01 HDB3, 10 AMI |
| data_o | output | 1 | Receive data or positive-rail data |
| neg_lcv_o | output | 1 | Negative-rail data (dual) or code-violation flag (single) |
| rclk_o | output | 1 | Receive clock, one period per bit |
| clklos_n_o | output | 1 | Loss of clock, active low |

## Verification
The properties assume that `mode_i` and `pol_inv_i` change only while the block is in reset or has lost signal; the edge-alignment checks are gated on those inputs being stable. The stimulus changes mode and polarity only during reset or while muted. It raises and lowers `los_n_i` only just after a bit edge, so the phase machine never stops halfway through a bit. The rails change once per bit period, between clock edges, and single-rail runs are either HDB3 streams produced by a model encoder or short sequences written by hand to contain a chosen violation.

// File: rtl/e1_rx_pkg.sv
package e1_rx_pkg;

    localparam int MODE_W   = 2;
    localparam int HDB3_WIN = 4;

    typedef enum logic [MODE_W-1:0] {
        RXM_DUAL     = 2'b00,
        RXM_HDB3     = 2'b01,
        RXM_AMI      = 2'b10,
        RXM_DUAL_ALT = 2'b11
    } rx_mode_e;

    typedef enum logic [2:0] {
        DS_VOID,
        DS_MARK,
        DS_ZERO1,
        DS_ZERO2,
        DS_ZERO3,
        DS_ZLONG
    } dec_state_e;

    typedef enum logic {
        PH_FIRST,
        PH_SECOND
    } half_e;

    function automatic logic mode_is_dual(input rx_mode_e m);
        return (m == RXM_DUAL) || (m == RXM_DUAL_ALT);
    endfunction

endpackage

// File: rtl/e1_rx_bit_phase.sv
module e1_rx_bit_phase
    import e1_rx_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run_i,
    output half_e half_o,
    output logic  bit_edge_o
);

    half_e half_q, half_d;

    always_ff @(posedge clk) begin
        if (!rst_n) half_q <= PH_FIRST;
        else        half_q <= half_d;
    end

    always_comb begin
        half_d     = half_q;
        bit_edge_o = 1'b0;
        unique case (half_q)
            PH_FIRST: begin
                if (run_i) half_d = PH_SECOND;
            end
            PH_SECOND: begin
                if (run_i) begin
                    half_d     = PH_FIRST;
                    bit_edge_o = 1'b1;
                end
            end
            default: half_d = PH_FIRST;
        endcase
    end

    assign half_o = half_q;

endmodule

// File: rtl/e1_rx_line_decoder.sv
module e1_rx_line_decoder
    import e1_rx_pkg::*;
#(
    parameter int WIN = HDB3_WIN
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step_i,
    input  rx_mode_e mode_i,
    input  logic     pos_i,
    input  logic     neg_i,
    output logic     dec_bit_o,
    output logic     code_err_o
);

    localparam int LAST = WIN - 1;

    dec_state_e     st_q, st_d;
    logic [WIN-1:0] dly_q, dly_d;
    logic           last_pol_q, last_pol_d;
    logic           vpol_q, vpol_d;
    logic           seen_v_q, seen_v_d;

    logic mark, mpol, repeat_pol, pattern_ok, v_removed, alt_bad, is_hdb3, is_ami;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= DS_VOID;
            dly_q      <= '0;
            last_pol_q <= 1'b0;
            vpol_q     <= 1'b0;
            seen_v_q   <= 1'b0;
        end else if (step_i) begin
            st_q       <= st_d;
            dly_q      <= dly_d;
            last_pol_q <= last_pol_d;
            vpol_q     <= vpol_d;
            seen_v_q   <= seen_v_d;
        end
    end

    always_comb begin
        mark = pos_i | neg_i;
        mpol = pos_i;
        st_d = st_q;
        unique case (st_q)
            DS_VOID:  st_d = mark ? DS_MARK : DS_VOID;
            DS_MARK:  st_d = mark ? DS_MARK : DS_ZERO1;
            DS_ZERO1: st_d = mark ? DS_MARK : DS_ZERO2;
            DS_ZERO2: st_d = mark ? DS_MARK : DS_ZERO3;
            DS_ZERO3: st_d = mark ? DS_MARK : DS_ZLONG;
            DS_ZLONG: st_d = mark ? DS_MARK : DS_ZLONG;
            default:  st_d = DS_VOID;
        endcase
    end

    always_comb begin
        is_hdb3    = (mode_i == RXM_HDB3);
        is_ami     = (mode_i == RXM_AMI);
        repeat_pol = mark && (st_q != DS_VOID) && (mpol == last_pol_q);
        pattern_ok = (st_q == DS_ZERO2) || (st_q == DS_ZERO3);
        v_removed  = is_hdb3 && repeat_pol && pattern_ok;
        alt_bad    = seen_v_q && (mpol == vpol_q);

        if (is_hdb3)     code_err_o = repeat_pol && (!pattern_ok || alt_bad);
        else if (is_ami) code_err_o = repeat_pol;
        else             code_err_o = 1'b0;

        if (v_removed) dly_d = '0;
        else           dly_d = {dly_q[WIN-2:0], mark};

        last_pol_d = mark ? mpol : last_pol_q;
        vpol_d     = v_removed ? mpol : vpol_q;
        seen_v_d   = seen_v_q | v_removed;
        dec_bit_o  = dly_q[LAST];
    end

endmodule

// File: rtl/e1_rx_out_stage.sv
module e1_rx_out_stage
    import e1_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     los_n_i,
    input  logic     mute_en_i,
    input  logic     pol_inv_i,
    input  rx_mode_e mode_i,
    input  logic     step_i,
    input  half_e    half_i,
    input  logic     pos_i,
    input  logic     neg_i,
    input  logic     dec_bit_i,
    input  logic     code_err_i,
    output logic     data_o,
    output logic     neg_lcv_o,
    output logic     rclk_o,
    output logic     clklos_n_o
);

    logic dual, inv, muted;

    always_comb begin
        dual  = mode_is_dual(mode_i);
        inv   = dual && pol_inv_i;
        muted = mute_en_i && !los_n_i;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o     <= 1'b0;
            neg_lcv_o  <= 1'b0;
            rclk_o     <= 1'b0;
            clklos_n_o <= 1'b1;
        end else begin
            clklos_n_o <= !muted;
            if (muted) begin
                rclk_o    <= !inv;
                data_o    <= inv;
                neg_lcv_o <= inv;
            end else if (los_n_i) begin
                rclk_o <= (half_i == PH_FIRST) ^ inv;
                if (step_i) begin
                    if (dual) begin
                        data_o    <= pos_i ^ inv;
                        neg_lcv_o <= neg_i ^ inv;
                    end else begin
                        data_o    <= dec_bit_i;
                        neg_lcv_o <= code_err_i;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/e1_rx_decoder.sv
module e1_rx_decoder
    import e1_rx_pkg::*;
#(
    parameter int WIN = HDB3_WIN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_pos_i,
    input  logic              rx_neg_i,
    input  logic              los_n_i,
    input  logic              mute_en_i,
    input  logic              pol_inv_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              data_o,
    output logic              neg_lcv_o,
    output logic              rclk_o,
    output logic              clklos_n_o
);

    rx_mode_e mode;
    half_e    half;
    logic     step, dec_bit, code_err;

    assign mode = rx_mode_e'(mode_i);

    e1_rx_bit_phase i_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (los_n_i),
        .half_o     (half),
        .bit_edge_o (step)
    );

    e1_rx_line_decoder #(.WIN(WIN)) i_dec (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_i     (step),
        .mode_i     (mode),
        .pos_i      (rx_pos_i),
        .neg_i      (rx_neg_i),
        .dec_bit_o  (dec_bit),
        .code_err_o (code_err)
    );

    e1_rx_out_stage i_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .los_n_i    (los_n_i),
        .mute_en_i  (mute_en_i),
        .pol_inv_i  (pol_inv_i),
        .mode_i     (mode),
        .step_i     (step),
        .half_i     (half),
        .pos_i      (rx_pos_i),
        .neg_i      (rx_neg_i),
        .dec_bit_i  (dec_bit),
        .code_err_i (code_err),
        .data_o     (data_o),
        .neg_lcv_o  (neg_lcv_o),
        .rclk_o     (rclk_o),
        .clklos_n_o (clklos_n_o)
    );

endmodule

// File: rtl/e1_rx_decoder_chk.sv
module e1_rx_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       los_n_i,
    input logic       mute_en_i,
    input logic       pol_inv_i,
    input logic [1:0] mode_i,
    input logic       data_o,
    input logic       neg_lcv_o,
    input logic       rclk_o,
    input logic       clklos_n_o
);

    logic dual, inv;
    assign dual = (mode_i[1] == mode_i[0]);
    assign inv  = dual && pol_inv_i;

    // R9
    los_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!los_n_i && !mute_en_i) |=> ($stable(rclk_o) && $stable(data_o) && $stable(neg_lcv_o)));

    // R8
    mute_clklos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_en_i && !los_n_i) |=> !clklos_n_o);

    // R8
    mute_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_en_i && !los_n_i && !dual) |=> (rclk_o && !data_o && !neg_lcv_o));

    // R3
    data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (los_n_i && $past(los_n_i) && $stable(mode_i) && $stable(pol_inv_i) && !$stable(data_o))
        |-> (rclk_o == inv));

    // R6
    flag_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (los_n_i && $past(los_n_i) && $stable(mode_i) && $stable(pol_inv_i) && !$stable(neg_lcv_o))
        |-> (rclk_o == inv));

endmodule

bind e1_rx_decoder e1_rx_decoder_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .los_n_i    (los_n_i),
    .mute_en_i  (mute_en_i),
    .pol_inv_i  (pol_inv_i),
    .mode_i     (mode_i),
    .data_o     (data_o),
    .neg_lcv_o  (neg_lcv_o),
    .rclk_o     (rclk_o),
    .clklos_n_o (clklos_n_o)
);

// File: tb/test_e1_rx_decoder.sv
module test_e1_rx_decoder;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       rx_pos = 1'b0, rx_neg = 1'b0;
    logic       los_n = 1'b1, mute_en = 1'b0, pol_inv = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       data_o, neg_lcv_o, rclk_o, clklos_n_o;

    e1_rx_decoder i_e1_rx_decoder (
        .clk(clk), .rst_n(rst_n), .rx_pos_i(rx_pos), .rx_neg_i(rx_neg),
        .los_n_i(los_n), .mute_en_i(mute_en), .pol_inv_i(pol_inv), .mode_i(mode),
        .data_o(data_o), .neg_lcv_o(neg_lcv_o), .rclk_o(rclk_o), .clklos_n_o(clklos_n_o)
    );

    int checks = 0;
    int failures = 0;

    logic [2:0] expq[$];
    string      tagq[$];
    event       mon_ev;

    logic src[0:63];
    logic ep[0:63], en[0:63];
    logic xd[0:63], xn[0:63];

    task automatic check1(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Scoreboard monitor: compares outputs after each bit edge
    always @(mon_ev) begin
        logic [2:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check1(t, "data_o", data_o, e[2]);
        check1(t, "neg_lcv_o", neg_lcv_o, e[1]);
        check1("R3", "rclk_o at update", rclk_o, e[0]);
    end

    function automatic logic exp_inv();
        return (mode[1] == mode[0]) && pol_inv;
    endfunction

    task automatic send_bit(input logic p, input logic n, input logic ed, input logic ex, input string tag);
        rx_pos = p;
        rx_neg = n;
        @(posedge clk); @(negedge clk);
        check1("R3", "rclk_o mid-bit", rclk_o, !exp_inv());
        @(posedge clk); @(negedge clk);
        expq.push_back({ed, ex, exp_inv()});
        tagq.push_back(tag);
        -> mon_ev;
        #1;
    endtask

    task automatic do_reset(input logic [1:0] m, input logic pinv);
        @(negedge clk);
        rst_n = 1'b0; rx_pos = 1'b0; rx_neg = 1'b0;
        los_n = 1'b1; mute_en = 1'b0; mode = m; pol_inv = pinv;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        check1("R1", "data_o in reset", data_o, 1'b0);
        check1("R1", "neg_lcv_o in reset", neg_lcv_o, 1'b0);
        check1("R1", "rclk_o in reset", rclk_o, 1'b0);
        check1("R1", "clklos_n_o in reset", clklos_n_o, 1'b1);
        rst_n = 1'b1;
    endtask

    task automatic hdb3_encode(input int n);
        logic last = 1'b0;
        int nb = 0;
        int i = 0;
        while (i < n) begin
            if (i + 3 < n && !src[i] && !src[i+1] && !src[i+2] && !src[i+3]) begin
                for (int j = 0; j < 4; j++) begin ep[i+j] = 1'b0; en[i+j] = 1'b0; end
                if (nb % 2 == 0) begin
                    last = ~last;
                    ep[i] = last; en[i] = ~last;
                end
                ep[i+3] = last; en[i+3] = ~last;
                nb = 0;
                i += 4;
            end else if (src[i]) begin
                last = ~last;
                ep[i] = last; en[i] = ~last;
                nb++;
                i++;
            end else begin
                ep[i] = 1'b0; en[i] = 1'b0;
                i++;
            end
        end
    endtask

    task automatic ami_encode(input int n);
        logic last = 1'b0;
        for (int i = 0; i < n; i++) begin
            if (src[i]) begin last = ~last; ep[i] = last; en[i] = ~last; end
            else begin ep[i] = 1'b0; en[i] = 1'b0; end
        end
    endtask

    task automatic fill_delayed(input int n);
        for (int k = 0; k < n; k++) begin
            xd[k] = (k >= 4) ? src[k-4] : 1'b0;
            xn[k] = 1'b0;
        end
    endtask

    task automatic los_pause();
        logic hd, hn, hc;
        los_n = 1'b0;
        hd = data_o; hn = neg_lcv_o; hc = rclk_o;
        for (int c = 0; c < 5; c++) begin
            rx_pos = c[0]; rx_neg = ~c[0];
            @(posedge clk); @(negedge clk);
        end
        check1("R9", "data_o held", data_o, hd);
        check1("R9", "neg_lcv_o held", neg_lcv_o, hn);
        check1("R9", "rclk_o held", rclk_o, hc);
        check1("R9", "clklos_n_o without mute", clklos_n_o, 1'b1);
        los_n = 1'b1;
    endtask

    task automatic run_seq(input int n, input string tag, input int pause_at);
        for (int k = 0; k < n; k++) begin
            if (k == pause_at) los_pause();
            send_bit(ep[k], en[k], xd[k], xn[k], tag);
        end
    endtask

    task automatic load_pattern(input logic [31:0] pat);
        for (int i = 0; i < 32; i++) src[i] = (i < 28) ? pat[31-i] : 1'b0;
    endtask

    initial begin
        #(100000 * 10);
        failures++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R2: dual rail, pass-through, non-inverted
        do_reset(2'b00, 1'b0);
        send_bit(1, 0, 1, 0, "R2");
        send_bit(0, 1, 0, 1, "R2");
        send_bit(1, 1, 1, 1, "R2");
        send_bit(0, 0, 0, 0, "R2");
        // R3: dual rail inverted outputs and clock
        do_reset(2'b11, 1'b1);
        send_bit(1, 0, 0, 1, "R3");
        send_bit(0, 1, 1, 0, "R3");
        send_bit(0, 0, 1, 1, "R3");

        // R4 R5: HDB3 stream, polarity control ignored in single rail (R3)
        do_reset(2'b01, 1'b1);
        load_pattern(32'h9000_8C40);
        hdb3_encode(32); fill_delayed(32);
        run_seq(32, "R4", -1);
        // R5 R9: stream starting with a B00V, paused mid-way by loss of signal
        do_reset(2'b01, 1'b0);
        load_pattern(32'h0F00_A100);
        hdb3_encode(32); fill_delayed(32);
        run_seq(32, "R5", 14);

        // R6: violation pulse with same polarity as the previous one
        do_reset(2'b01, 1'b0);
        for (int i = 0; i < 12; i++) begin ep[i] = (i == 0 || i == 4 || i == 8); en[i] = 1'b0; src[i] = (i == 0); end
        fill_delayed(12);
        xn[8] = 1'b1;
        run_seq(12, "R6", -1);
        // R6: violation pulse not ending a valid pattern is kept as a mark
        do_reset(2'b01, 1'b0);
        for (int i = 0; i < 8; i++) begin ep[i] = (i == 0); en[i] = (i == 1 || i == 2); src[i] = (i < 3); end
        fill_delayed(8);
        xn[2] = 1'b1;
        run_seq(8, "R6", -1);

        // R7: AMI valid stream and a bipolar violation
        do_reset(2'b10, 1'b0);
        load_pattern(32'hB5A0_9C30);
        ami_encode(32); fill_delayed(32);
        run_seq(32, "R7", -1);
        do_reset(2'b10, 1'b0);
        for (int i = 0; i < 8; i++) begin ep[i] = (i == 0 || i == 2); en[i] = (i == 4); src[i] = (i == 0 || i == 2 || i == 4); end
        fill_delayed(8);
        xn[2] = 1'b1;
        run_seq(8, "R7", -1);

        // R8: muted outputs under each mode/polarity
        do_reset(2'b00, 1'b0);
        send_bit(1, 1, 1, 1, "R2");
        los_n = 1'b0; mute_en = 1'b1;
        @(posedge clk); @(negedge clk);
        check1("R8", "clklos_n_o muted", clklos_n_o, 1'b0);
        check1("R8", "rclk_o muted dual", rclk_o, 1'b1);
        check1("R8", "data_o muted dual", data_o, 1'b0);
        check1("R8", "neg_lcv_o muted dual", neg_lcv_o, 1'b0);
        pol_inv = 1'b1;
        @(posedge clk); @(negedge clk);
        check1("R8", "rclk_o muted dual inv", rclk_o, 1'b0);
        check1("R8", "data_o muted dual inv", data_o, 1'b1);
        check1("R8", "neg_lcv_o muted dual inv", neg_lcv_o, 1'b1);
        mode = 2'b01;
        @(posedge clk); @(negedge clk);
        check1("R8", "rclk_o muted single", rclk_o, 1'b1);
        check1("R8", "data_o muted single", data_o, 1'b0);
        check1("R8", "neg_lcv_o muted single", neg_lcv_o, 1'b0);
        los_n = 1'b1; mute_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check1("R8", "clklos_n_o after recovery", clklos_n_o, 1'b1);
        do_reset(2'b00, 1'b0);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule